// File: doc/BRIEF.md
# Filtered Comparator Edge-Interrupt Controller

This block takes the raw output of an analog comparator, which changes with no relation to the bus clock, and turns it into clean, clock-aligned edge events. The raw bit first goes through a flop synchroniser. It then goes through a majority-free run filter. The filter accepts a new level only after a fixed number of consecutive sample instants have seen that level. The sample instants come from one of two sources: an internal divider that counts bus-clock cycles, or an external sample strobe. When the internal source is chosen and its period is zero, the filter is bypassed.

Rising and falling transitions of the filtered level set two sticky flags. Each flag is cleared by writing 1 to its bit. Each flag has its own enable, and a single interrupt line is raised while any enabled flag is pending. Software reaches the controls through a byte-wide register port with a 2-bit address. Writes take effect at the clock edge and reads are combinational.

Top module: `cmp_edge_intc`

## Requirements
- R1: After synchronous reset every register reads 0x00, both flags are clear, the filtered level is 0 and `irq` is low.
- R2: The raw comparator bit passes through two flops before it reaches the filter. With the filter bypassed, a raw change shows in status bit 0 after three clock edges and not after two.
- R3: Address 1 holds the sample period in clock cycles. With address 0 bit 0 at 0 and a nonzero period P, a strobe occurs once every P cycles. The filtered level takes a new value only after 4 consecutive strobes have seen that value.
- R4: With address 0 bit 0 at 0 and a period of 0, the filter is bypassed. Status bit 0 follows the synchronised input one cycle later.
- R5: With address 0 bit 0 at 1, the period field has no effect: a value of zero does not bypass the filter, and a nonzero value makes no strobes. Each cycle with `smp_ext` high counts as one strobe.
- R6: Status register (address 2): bit 2 is the rising flag, set by a 0-to-1 change of the filtered level. Bit 1 is the falling flag, set by a 1-to-0 change. Bit 0 reads the current filtered level.
- R7: Writing 1 to status bit 2 or bit 1 clears that flag. Writing 0 leaves it unchanged.
- R8: If a flag is set by an edge in the same cycle as a write-one-clear of that flag, the flag ends up set.
- R9: Status bit 4 enables the rising flag and bit 3 enables the falling flag. `irq` is high exactly while an enabled flag is set.
- R10: Status bits 7 to 5, address 0 bits 7 to 1, and all of address 3 read 0 and ignore writes.
- R11: Every write to address 1 restarts the period counter. If that address is rewritten more often than every P cycles, no internal strobe occurs.
- R12: A change of the synchronised input that lasts fewer than 4 consecutive strobes leaves the filtered level and both flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_raw | input | 1 | Asynchronous comparator output |
| smp_ext | input | 1 | External sample strobe, synchronous to clk |
| reg_addr | input | 2 | Register select |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its defaults: an 8-bit period, a run length of 4 and two synchroniser stages. With these values, periods of 1, 4 and 5 cycles expose the filter latency within a few dozen cycles, and a 3-strobe glitch lands just one short of acceptance. The bench sweeps the offset of a clear write across the edge-to-flag path, so one offset hits the exact cycle where a set and a clear coincide. A behavioural model built from queues and integers tracks the level, the flags and the interrupt line, and is compared with them on every clock.

// File: rtl/cmp_edge_pkg.sv
`timescale 1ns/1ps
package cmp_edge_pkg;

    localparam int unsigned BUS_W = 8;

    typedef enum logic [1:0] {
        REG_CTRL   = 2'd0,
        REG_PERIOD = 2'd1,
        REG_STAT   = 2'd2,
        REG_SPARE  = 2'd3
    } reg_sel_e;

    localparam int unsigned CTRL_EXT_BIT = 0;
    localparam int unsigned STAT_RIE_BIT = 4;
    localparam int unsigned STAT_FIE_BIT = 3;
    localparam int unsigned STAT_RFL_BIT = 2;
    localparam int unsigned STAT_FFL_BIT = 1;
    localparam int unsigned STAT_LVL_BIT = 0;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_t;

    typedef struct packed {
        logic rise_ie;
        logic fall_ie;
        logic rise_fl;
        logic fall_fl;
        logic level;
    } stat_t;

    function automatic logic [BUS_W-1:0] stat_to_byte(input stat_t s);
        logic [BUS_W-1:0] b;
        b = '0;
        b[STAT_RIE_BIT] = s.rise_ie;
        b[STAT_FIE_BIT] = s.fall_ie;
        b[STAT_RFL_BIT] = s.rise_fl;
        b[STAT_FFL_BIT] = s.fall_fl;
        b[STAT_LVL_BIT] = s.level;
        return b;
    endfunction

endpackage

// File: rtl/cmp_sync.sv
`timescale 1ns/1ps
module cmp_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[0] <= 1'b0;
                    else     chain_q[0] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[i] <= 1'b0;
                    else     chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/cmp_strobe_gen.sv
`timescale 1ns/1ps
module cmp_strobe_gen #(
    parameter int unsigned PER_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ext_sel,
    input  logic             ext_smp,
    input  logic [PER_W-1:0] period,
    input  logic             reload,
    output logic             strobe,
    output logic             bypass
);
    logic [PER_W-1:0] cnt_q;
    logic             run;
    logic             at_end;

    assign run    = !ext_sel && (period != '0);
    assign at_end = (cnt_q == period - PER_W'(1));

    always_ff @(posedge clk) begin
        if (rst || reload || !run) cnt_q <= '0;
        else if (at_end)           cnt_q <= '0;
        else                       cnt_q <= cnt_q + PER_W'(1);
    end

    assign strobe = ext_sel ? ext_smp : (run && at_end);
    assign bypass = !ext_sel && (period == '0);

    // R3
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt_q < period));

    // R5
    ext_no_count_chk: assert property (@(posedge clk) disable iff (rst)
        $past(ext_sel) |-> (cnt_q == '0));
endmodule

// File: rtl/cmp_glitch_filter.sv
`timescale 1ns/1ps
module cmp_glitch_filter
    import cmp_edge_pkg::*;
#(
    parameter int unsigned RUN_N = 4
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  din,
    input  logic  strobe,
    input  logic  bypass,
    output logic  level,
    output edge_t edges
);
    localparam int unsigned CW = (RUN_N > 1) ? $clog2(RUN_N) : 1;
    localparam logic [CW-1:0] LAST = CW'(RUN_N - 1);

    logic          lvl_q;
    logic          lvl_prev_q;
    logic [CW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q <= 1'b0;
            run_q <= '0;
        end else if (bypass) begin
            lvl_q <= din;
            run_q <= '0;
        end else if (strobe) begin
            if (din == lvl_q) begin
                run_q <= '0;
            end else if (run_q == LAST) begin
                lvl_q <= din;
                run_q <= '0;
            end else begin
                run_q <= run_q + CW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) lvl_prev_q <= 1'b0;
        else     lvl_prev_q <= lvl_q;
    end

    assign level      = lvl_q;
    assign edges.rise = lvl_q & ~lvl_prev_q;
    assign edges.fall = ~lvl_q & lvl_prev_q;

    // R12
    lvl_on_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        (lvl_q != $past(lvl_q)) |-> $past(strobe || bypass));

    // R3
    lvl_takes_input_chk: assert property (@(posedge clk) disable iff (rst)
        (lvl_q != $past(lvl_q)) |-> (lvl_q == $past(din)));
endmodule

// File: rtl/cmp_edge_intc.sv
`timescale 1ns/1ps
module cmp_edge_intc
    import cmp_edge_pkg::*;
#(
    parameter int unsigned PER_W  = 8,
    parameter int unsigned RUN_N  = 4,
    parameter int unsigned SYNC_N = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmp_raw,
    input  logic             smp_ext,
    input  logic [1:0]       reg_addr,
    input  logic             reg_we,
    input  logic [BUS_W-1:0] reg_wdata,
    output logic [BUS_W-1:0] reg_rdata,
    output logic             irq
);
    logic             ext_sel_q;
    logic [PER_W-1:0] period_q;
    logic             rie_q, fie_q, rfl_q, ffl_q;
    logic             cmp_s, strobe, bypass, level;
    edge_t            edges;
    logic             wr_ctrl, wr_per, wr_stat;
    logic             clr_rise, clr_fall;
    stat_t            stat;

    assign wr_ctrl  = reg_we && (reg_addr == REG_CTRL);
    assign wr_per   = reg_we && (reg_addr == REG_PERIOD);
    assign wr_stat  = reg_we && (reg_addr == REG_STAT);
    assign clr_rise = wr_stat && reg_wdata[STAT_RFL_BIT];
    assign clr_fall = wr_stat && reg_wdata[STAT_FFL_BIT];

    cmp_sync #(.STAGES(SYNC_N)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (cmp_raw),
        .q_sync  (cmp_s)
    );

    cmp_strobe_gen #(.PER_W(PER_W)) u_stb (
        .clk     (clk),
        .rst     (rst),
        .ext_sel (ext_sel_q),
        .ext_smp (smp_ext),
        .period  (period_q),
        .reload  (wr_per),
        .strobe  (strobe),
        .bypass  (bypass)
    );

    cmp_glitch_filter #(.RUN_N(RUN_N)) u_filt (
        .clk    (clk),
        .rst    (rst),
        .din    (cmp_s),
        .strobe (strobe),
        .bypass (bypass),
        .level  (level),
        .edges  (edges)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ext_sel_q <= 1'b0;
            period_q  <= '0;
            rie_q     <= 1'b0;
            fie_q     <= 1'b0;
        end else begin
            if (wr_ctrl) ext_sel_q <= reg_wdata[CTRL_EXT_BIT];
            if (wr_per)  period_q  <= reg_wdata[PER_W-1:0];
            if (wr_stat) begin
                rie_q <= reg_wdata[STAT_RIE_BIT];
                fie_q <= reg_wdata[STAT_FIE_BIT];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rfl_q <= 1'b0;
            ffl_q <= 1'b0;
        end else begin
            rfl_q <= edges.rise | (rfl_q & ~clr_rise);
            ffl_q <= edges.fall | (ffl_q & ~clr_fall);
        end
    end

    assign stat = '{rise_ie: rie_q, fall_ie: fie_q, rise_fl: rfl_q,
                    fall_fl: ffl_q, level: level};

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            REG_CTRL:   reg_rdata[CTRL_EXT_BIT] = ext_sel_q;
            REG_PERIOD: reg_rdata = BUS_W'(period_q);
            REG_STAT:   reg_rdata = stat_to_byte(stat);
            default:    reg_rdata = '0;
        endcase
    end

    assign irq = (rfl_q & rie_q) | (ffl_q & fie_q);

    // R8
    set_wins_rise_chk: assert property (@(posedge clk) disable iff (rst)
        edges.rise |=> rfl_q);

    // R8
    set_wins_fall_chk: assert property (@(posedge clk) disable iff (rst)
        edges.fall |=> ffl_q);

    // R7
    w1c_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_rise && !edges.rise) |=> !rfl_q);

    // R9
    irq_needs_flag_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> (rfl_q || ffl_q));
endmodule

// File: tb/test_cmp_edge_intc.sv
`timescale 1ns/1ps
module test_cmp_edge_intc;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmp_raw = 1'b0;
    logic       smp_ext = 1'b0;
    logic [1:0] reg_addr = 2'd2;
    logic       reg_we = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq;

    int    n_chk  = 0;
    int    n_fail = 0;
    bit    mon_en = 1'b0;
    bit    done   = 1'b0;
    string cur_tag = "R1";

    always #2.5 clk = ~clk;

    cmp_edge_intc i_cmp_edge_intc (
        .clk       (clk),
        .rst       (rst),
        .cmp_raw   (cmp_raw),
        .smp_ext   (smp_ext),
        .reg_addr  (reg_addr),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq       (irq)
    );

    // behavioural reference model
    bit sync_q[$];
    bit m_ext, m_lvl, m_lvl_prev, m_rie, m_fie, m_rf, m_ff;
    int m_per, m_cnt, m_run;

    function automatic logic [7:0] m_rd(input logic [1:0] a);
        case (a)
            2'd0:    return {7'b0, m_ext};
            2'd1:    return 8'(m_per);
            2'd2:    return {3'b0, m_rie, m_fie, m_rf, m_ff, m_lvl};
            default: return 8'h00;
        endcase
    endfunction

    function automatic bit m_irq();
        return (m_rf && m_rie) || (m_ff && m_fie);
    endfunction

    always @(posedge clk) begin
        bit cs, stb, byp, rise, fall, w0, w1, w2;
        if (rst) begin
            sync_q = {1'b0, 1'b0};
            m_ext = 0; m_lvl = 0; m_lvl_prev = 0; m_rie = 0; m_fie = 0;
            m_rf = 0; m_ff = 0; m_per = 0; m_cnt = 0; m_run = 0;
        end else begin
            cs = sync_q.pop_front();
            sync_q.push_back(cmp_raw);
            w0 = reg_we && reg_addr == 2'd0;
            w1 = reg_we && reg_addr == 2'd1;
            w2 = reg_we && reg_addr == 2'd2;
            stb  = m_ext ? smp_ext : (m_per != 0 && m_cnt == m_per - 1);
            byp  = !m_ext && m_per == 0;
            rise = m_lvl && !m_lvl_prev;
            fall = !m_lvl && m_lvl_prev;
            if (w1 || m_ext || m_per == 0) m_cnt = 0;
            else if (m_cnt == m_per - 1)   m_cnt = 0;
            else                           m_cnt++;
            m_lvl_prev = m_lvl;
            if (byp) begin
                m_lvl = cs; m_run = 0;
            end else if (stb) begin
                if (cs == m_lvl) m_run = 0;
                else if (m_run == 3) begin m_lvl = cs; m_run = 0; end
                else m_run++;
            end
            m_rf = rise || (m_rf && !(w2 && reg_wdata[2]));
            m_ff = fall || (m_ff && !(w2 && reg_wdata[1]));
            if (w0) m_ext = reg_wdata[0];
            if (w1) m_per = int'(reg_wdata);
            if (w2) begin m_rie = reg_wdata[4]; m_fie = reg_wdata[3]; end
        end
    end

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && mon_en && !done) begin
            chk(irq === m_irq(), {cur_tag, " irq vs model"}, 32'(irq), 32'(m_irq()));
            if (!reg_we)
                chk(reg_rdata === m_rd(reg_addr), {cur_tag, " rdata vs model"},
                    32'(reg_rdata), 32'(m_rd(reg_addr)));
        end
    end

    task automatic idle(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        reg_addr = a; reg_we = 1'b1; reg_wdata = d;
        @(posedge clk); #1;
        reg_we = 1'b0; reg_addr = 2'd2; reg_wdata = 8'h00;
    endtask

    task automatic rd_chk(input logic [1:0] a, input logic [7:0] exp, input string tag);
        reg_addr = a;
        @(negedge clk);
        chk(reg_rdata === exp, tag, 32'(reg_rdata), 32'(exp));
        @(posedge clk); #1;
        reg_addr = 2'd2;
    endtask

    task automatic irq_chk(input bit exp, input string tag);
        @(negedge clk);
        chk(irq === exp, tag, 32'(irq), 32'(exp));
        @(posedge clk); #1;
    endtask

    task automatic pulse_ext(input int n);
        for (int i = 0; i < n; i++) begin
            smp_ext = 1'b1; idle(1);
            smp_ext = 1'b0; idle(2);
        end
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst = 1'b0;
        mon_en = 1'b1;

        // R1 reset values
        cur_tag = "R1";
        for (int a = 0; a < 4; a++) rd_chk(2'(a), 8'h00, "R1 reset read");
        irq_chk(1'b0, "R1 reset irq");

        // R2 two-flop synchroniser, filter bypassed (period 0)
        cur_tag = "R2";
        cmp_raw = 1'b1;
        repeat (3) @(negedge clk);
        chk(reg_rdata[0] === 1'b0, "R2 level after two edges", 32'(reg_rdata[0]), 0);
        @(negedge clk);
        chk(reg_rdata[0] === 1'b1, "R2 level after three edges", 32'(reg_rdata[0]), 1);
        @(posedge clk); #1;
        idle(3);
        rd_chk(2'd2, 8'h05, "R6 rising flag and level");

        // R4 bypass follows input down
        cur_tag = "R4";
        cmp_raw = 1'b0;
        idle(6);
        rd_chk(2'd2, 8'h06, "R4 bypass level low, R6 both flags");

        // R7 write-one-to-clear
        cur_tag = "R7";
        wr(2'd2, 8'h00);
        rd_chk(2'd2, 8'h06, "R7 zero write keeps flags");
        wr(2'd2, 8'h04);
        rd_chk(2'd2, 8'h02, "R7 clear rising only");
        wr(2'd2, 8'h02);
        rd_chk(2'd2, 8'h00, "R7 clear falling");

        // R9 interrupt enables
        cur_tag = "R9";
        wr(2'd2, 8'h10);
        cmp_raw = 1'b1; idle(6);
        cmp_raw = 1'b0; idle(6);
        rd_chk(2'd2, 8'h16, "R9 both flags, rising enabled");
        irq_chk(1'b1, "R9 irq from rising");
        wr(2'd2, 8'h14);
        irq_chk(1'b0, "R9 falling pending but disabled");
        wr(2'd2, 8'h08);
        irq_chk(1'b1, "R9 irq from falling");
        wr(2'd2, 8'h02);
        irq_chk(1'b0, "R9 all cleared");

        // R10 reserved bits
        cur_tag = "R10";
        wr(2'd2, 8'hE0);
        rd_chk(2'd2, 8'h00, "R10 status high bits");
        wr(2'd3, 8'hFF);
        rd_chk(2'd3, 8'h00, "R10 spare address");
        wr(2'd0, 8'hFE);
        rd_chk(2'd0, 8'h00, "R10 control upper bits");

        // R12 short glitches rejected, period 1
        cur_tag = "R12";
        wr(2'd1, 8'd1);
        rd_chk(2'd1, 8'd1, "R3 period readback");
        cmp_raw = 1'b1; idle(2); cmp_raw = 1'b0; idle(12);
        rd_chk(2'd2, 8'h00, "R12 two-strobe glitch");
        cmp_raw = 1'b1; idle(3); cmp_raw = 1'b0; idle(12);
        rd_chk(2'd2, 8'h00, "R12 three-strobe glitch");

        // R3 period 5, four strobes needed
        cur_tag = "R3";
        wr(2'd1, 8'd5);
        cmp_raw = 1'b1; idle(10);
        rd_chk(2'd2, 8'h00, "R3 level not yet changed");
        idle(30);
        rd_chk(2'd2, 8'h05, "R3 level accepted");
        cmp_raw = 1'b0; idle(40);
        wr(2'd2, 8'h06);
        rd_chk(2'd2, 8'h00, "R3 back low, flags cleared");

        // R11 period rewrite restarts counter
        cur_tag = "R11";
        wr(2'd1, 8'd4);
        cmp_raw = 1'b1;
        for (int i = 0; i < 15; i++) wr(2'd1, 8'd4);
        rd_chk(2'd2, 8'h00, "R11 no strobe while rewritten");
        idle(30);
        rd_chk(2'd2, 8'h05, "R11 strobes resume");
        cmp_raw = 1'b0; idle(30);
        wr(2'd2, 8'h06);

        // R5 external strobe
        cur_tag = "R5";
        wr(2'd0, 8'h01);
        cmp_raw = 1'b1; idle(30);
        rd_chk(2'd2, 8'h00, "R5 period ignored");
        pulse_ext(4);
        idle(2);
        rd_chk(2'd2, 8'h05, "R5 four external strobes");
        wr(2'd1, 8'd0);
        cmp_raw = 1'b0; idle(20);
        rd_chk(2'd2, 8'h05, "R5 zero period no bypass");
        pulse_ext(4);
        idle(2);
        rd_chk(2'd2, 8'h06, "R5 external falling accepted");
        wr(2'd2, 8'h06);
        wr(2'd0, 8'h00);

        // R8 set versus clear in the same cycle, bypass mode
        cur_tag = "R8";
        for (int k = 0; k < 8; k++) begin
            cmp_raw = 1'b1; idle(k);
            wr(2'd2, 8'h06);
            idle(4);
            rd_chk(2'd2, (k <= 2) ? 8'h05 : 8'h01, "R8 rising set vs clear");
            wr(2'd2, 8'h06);
            cmp_raw = 1'b0; idle(k);
            wr(2'd2, 8'h02);
            idle(4);
            rd_chk(2'd2, (k <= 2) ? 8'h02 : 8'h00, "R8 falling set vs clear");
            wr(2'd2, 8'h06);
        end

        idle(4);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule